// File: doc/BRIEF.md
# Two-Layer Stub Correlation Window

This block pairs hits from two stacked strip-sensor layers. Every channel has an
already-filtered cluster flag for the lower layer and one for the upper layer. A
lower-layer cluster becomes a stub when at least one upper-layer cluster lies in a
window around it. The window has a programmable half-width, which sets the
transverse-momentum cut. A programmable signed offset moves the window sideways
to cancel the geometric displacement across the module.

Eleven upper-layer flags come in from each adjacent chip, so windows that cross a
chip edge are evaluated in full. The chip's own eleven outermost upper-layer flags
go out on each side. Once per crossing the block registers the per-channel stub
vector and a single trigger bit, which is the OR of all stubs.

For test, a load strobe captures the stub result into a shift register. A two-state
controller then sends it out serially, one channel per clock, starting from the
lowest channel. The controller has two states. `SR_IDLE` leaves on a load (transition
LOAD). `SR_RUN` re-enters itself on a load (RELOAD), steps through the bits
otherwise (STEP), and returns to `SR_IDLE` after the last bit (DONE).

Top module: `stub_correlator`

## Requirements
- R1: `stub_vec[i]` is 1 exactly when `bot_clu[i]` is 1 and some upper-layer position p with |p − (i + offset)| ≤ half-width holds a cluster. Position p in 0..NCH−1 is `top_clu[p]`. Position −1−k is `top_from_lo[k]`. Position NCH+k is `top_from_hi[k]`.
- R2: `cfg_half` is a 4-bit unsigned half-width. Values 9..15 act as 8, and 0 accepts only the window centre.
- R3: `cfg_off` is a 3-bit two's-complement offset, where a positive value moves the window to higher channel numbers. The value −4 (3'b100) acts as −3.
- R4: Window positions below −11 or above NCH+10 hold no cluster. An upper-layer cluster with no lower-layer cluster in range produces no stub and no trigger.
- R5: `stub_vec` and `trig` change on the first rising clock edge after the inputs are applied, and `trig` equals the OR of `stub_vec`.
- R6: `top_to_lo[k]` equals `top_clu[k]` and `top_to_hi[k]` equals `top_clu[NCH−1−k]`. Both are combinational.
- R7: A clock edge with `sr_load`=1 captures the stub result of the inputs present at that same edge. After that edge, `sr_valid` stays 1 for NCH cycles and `sr_out` gives channel 0, 1, …, NCH−1 in turn.
- R8: `sr_load` during shifting restarts the sequence with a fresh capture.
- R9: While `rst_n` is 0 at a clock edge, `stub_vec`, `trig`, `sr_out` and `sr_valid` become 0.
- R10: When `sr_valid` is 0, `sr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_half | input | 4 | Window half-width, unsigned |
| cfg_off | input | 3 | Window offset, two's complement |
| bot_clu | input | NCH | Lower-layer cluster flags |
| top_clu | input | NCH | Upper-layer cluster flags |
| top_from_lo | input | 11 | Upper-layer flags of the lower adjacent chip, k = distance−1 |
| top_from_hi | input | 11 | Upper-layer flags of the upper adjacent chip, k = distance−1 |
| sr_load | input | 1 | Capture stub result and start serial output |
| top_to_lo | output | 11 | Own lowest upper-layer flags for the lower adjacent chip |
| top_to_hi | output | 11 | Own highest upper-layer flags for the upper adjacent chip |
| stub_vec | output | NCH | Registered per-channel stubs |
| trig | output | 1 | Registered OR of all stubs |
| sr_out | output | 1 | Serial stub bit |
| sr_valid | output | 1 | Serial output active |

## Verification
Two functions share one clock edge here. The first is the capture into the test shift register. The second is the registering of a fresh correlation result and its trigger. The bench raises `sr_load` in the same cycle that a new cluster pattern is applied. It then checks that `trig` rises on that edge and that the serial bits reproduce the stub vector computed from that pattern. A second collision puts a load in the middle of a shift. That case is judged by the first serial bit of the new pattern and by `sr_valid` lasting a full NCH cycles after the reload.

// File: rtl/stub_pkg.sv
package stub_pkg;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_RUN  = 1'b1
    } sr_state_t;

    localparam int HW_MAX = 8;
    localparam int OFF_MAG = 3;
    localparam int EDGE = HW_MAX + OFF_MAG;

endpackage

// File: rtl/stub_match_chan.sv
module stub_match_chan #(
    parameter int CH    = 0,
    parameter int EXTW  = 54,
    parameter int EDGE  = 11,
    parameter int HWMAX = 8,
    parameter int HW_W  = 4,
    parameter int OFF_W = 3
) (
    input  logic                    bot,
    input  logic [EXTW-1:0]         ext,
    input  logic [HW_W-1:0]         hw,
    input  logic signed [OFF_W-1:0] off,
    output logic                    stub
);
    localparam int IW = $clog2(EXTW);

    logic hit;

    always_comb begin
        int p;
        int ad;
        hit = 1'b0;
        for (int d = -HWMAX; d <= HWMAX; d++) begin
            p  = CH + EDGE + int'(off) + d;
            ad = (d < 0) ? -d : d;
            if (p >= 0 && p < EXTW && ad <= int'(hw)) begin
                if (ext[p[IW-1:0]]) hit = 1'b1;
            end
        end
    end

    assign stub = bot & hit;

endmodule

// File: rtl/stub_shift_fsm.sv
module stub_shift_fsm
    import stub_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [NCH-1:0] din,
    output logic           sout,
    output logic           svalid
);
    localparam int CW = $clog2(NCH);
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    sr_state_t      state_q, state_d;
    logic [NCH-1:0] sreg_q, sreg_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SR_IDLE;
            sreg_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sreg_q  <= sreg_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        sreg_d  = sreg_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SR_IDLE: begin
                if (load) begin
                    state_d = SR_RUN;
                    sreg_d  = din;
                    cnt_d   = '0;
                end
            end
            SR_RUN: begin
                if (load) begin
                    sreg_d = din;
                    cnt_d  = '0;
                end else if (cnt_q == LAST) begin
                    state_d = SR_IDLE;
                    sreg_d  = '0;
                    cnt_d   = '0;
                end else begin
                    sreg_d = sreg_q >> 1;
                    cnt_d  = cnt_q + 1'b1;
                end
            end
            default: state_d = SR_IDLE;
        endcase
    end

    assign svalid = (state_q == SR_RUN);
    assign sout   = svalid & sreg_q[0];

    // run-length watcher, independent of the shift counter
    int run_len;
    always_ff @(posedge clk) begin
        if (!rst_n)       run_len <= 0;
        else if (load)    run_len <= 1;
        else if (svalid)  run_len <= run_len + 1;
        else              run_len <= 0;
    end

    assert_run_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        svalid |-> (run_len >= 1 && run_len <= NCH));

    assert_load_first_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (svalid && sout == $past(din[0])));

    assert_full_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (svalid && run_len < NCH && !load) |=> svalid);

endmodule

// File: rtl/stub_correlator.sv
module stub_correlator
    import stub_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [3:0]     cfg_half,
    input  logic [2:0]     cfg_off,
    input  logic [NCH-1:0] bot_clu,
    input  logic [NCH-1:0] top_clu,
    input  logic [10:0]    top_from_lo,
    input  logic [10:0]    top_from_hi,
    input  logic           sr_load,
    output logic [10:0]    top_to_lo,
    output logic [10:0]    top_to_hi,
    output logic [NCH-1:0] stub_vec,
    output logic           trig,
    output logic           sr_out,
    output logic           sr_valid
);
    localparam int EXTW = NCH + 2 * EDGE;

    logic [EXTW-1:0]   ext;
    logic [3:0]        hw_eff;
    logic signed [2:0] off_eff;
    logic [NCH-1:0]    stub_c;
    logic [NCH-1:0]    stub_q;
    logic              trig_q;

    assign hw_eff  = (cfg_half > 4'(HW_MAX)) ? 4'(HW_MAX) : cfg_half;
    assign off_eff = (cfg_off == 3'b100) ? 3'sb101 : $signed(cfg_off);

    always_comb begin
        ext = '0;
        for (int k = 0; k < EDGE; k++) begin
            ext[EDGE - 1 - k]   = top_from_lo[k];
            ext[EDGE + NCH + k] = top_from_hi[k];
        end
        ext[EDGE +: NCH] = top_clu;
    end

    genvar g;
    generate
        for (g = 0; g < EDGE; g++) begin : g_edge
            assign top_to_lo[g] = top_clu[g];
            assign top_to_hi[g] = top_clu[NCH - 1 - g];
        end
        for (g = 0; g < NCH; g++) begin : g_chan
            stub_match_chan #(
                .CH(g), .EXTW(EXTW), .EDGE(EDGE), .HWMAX(HW_MAX),
                .HW_W(4), .OFF_W(3)
            ) u_chan (
                .bot (bot_clu[g]),
                .ext (ext),
                .hw  (hw_eff),
                .off (off_eff),
                .stub(stub_c[g])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stub_q <= '0;
            trig_q <= 1'b0;
        end else begin
            stub_q <= stub_c;
            trig_q <= |stub_c;
        end
    end

    assign stub_vec = stub_q;
    assign trig     = trig_q;

    stub_shift_fsm #(.NCH(NCH)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sr_load),
        .din   (stub_c),
        .sout  (sr_out),
        .svalid(sr_valid)
    );

    assert_trig_is_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig == (|stub_vec));

    assert_stub_needs_bottom_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (stub_vec & ~$past(bot_clu)) == '0);

    assert_no_top_no_stub_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(top_clu) == '0 && $past(top_from_lo) == '0 && $past(top_from_hi) == '0)
        |-> !trig);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sr_valid) |-> !sr_out);

endmodule

// File: tb/test_stub_correlator.sv
module test_stub_correlator;
    localparam int NCH  = 32;
    localparam int EDGE = 11;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [3:0]     cfg_half;
    logic [2:0]     cfg_off;
    logic [NCH-1:0] bot_clu, top_clu;
    logic [10:0]    top_from_lo, top_from_hi;
    logic           sr_load;
    logic [10:0]    top_to_lo, top_to_hi;
    logic [NCH-1:0] stub_vec;
    logic           trig, sr_out, sr_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    stub_correlator #(.NCH(NCH)) i_stub_correlator (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half), .cfg_off(cfg_off),
        .bot_clu(bot_clu), .top_clu(top_clu),
        .top_from_lo(top_from_lo), .top_from_hi(top_from_hi),
        .sr_load(sr_load), .top_to_lo(top_to_lo), .top_to_hi(top_to_hi),
        .stub_vec(stub_vec), .trig(trig), .sr_out(sr_out), .sr_valid(sr_valid)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic top_at(int p, logic [NCH-1:0] t, logic [10:0] lo, logic [10:0] hi);
        if (p < 0)        return (-1 - p < EDGE) ? lo[-1 - p] : 1'b0;
        else if (p >= NCH) return (p - NCH < EDGE) ? hi[p - NCH] : 1'b0;
        else               return t[p];
    endfunction

    function automatic logic [NCH-1:0] model(logic [NCH-1:0] b, logic [NCH-1:0] t,
            logic [10:0] lo, logic [10:0] hi, logic [3:0] half, logic [2:0] off);
        int hw;
        int o;
        logic [NCH-1:0] r;
        hw = (half > 8) ? 8 : int'(half);
        o  = int'($signed(off));
        if (o == -4) o = -3;
        r = '0;
        for (int i = 0; i < NCH; i++)
            if (b[i])
                for (int p = i + o - hw; p <= i + o + hw; p++)
                    if (top_at(p, t, lo, hi)) r[i] = 1'b1;
        return r;
    endfunction

    task automatic apply(input logic [NCH-1:0] b, input logic [NCH-1:0] t,
            input logic [10:0] lo, input logic [10:0] hi, input logic [3:0] half,
            input logic [2:0] off, input string req);
        logic [NCH-1:0] e;
        bot_clu = b; top_clu = t; top_from_lo = lo; top_from_hi = hi;
        cfg_half = half; cfg_off = off;
        e = model(b, t, lo, hi, half, off);
        @(posedge clk); @(negedge clk);
        chk(req, 64'(stub_vec), 64'(e));
        chk({req, " trig"}, 64'(trig), 64'(|e));
    endtask

    task automatic t_reset();
        chk("R9 stub", 64'(stub_vec), 64'd0);
        chk("R9 trig", 64'(trig), 64'd0);
        chk("R9 valid", 64'(sr_valid), 64'd0);
        chk("R10 sr_out idle", 64'(sr_out), 64'd0);
    endtask

    task automatic t_basic();
        logic [NCH-1:0] b;
        logic [NCH-1:0] t;
        b = NCH'(1) << 10; t = NCH'(1) << 12;
        bot_clu = b; top_clu = t; top_from_lo = '0; top_from_hi = '0;
        cfg_half = 4'd2; cfg_off = 3'd0;
        #1 chk("R5 no change before edge", 64'(stub_vec), 64'd0);
        @(posedge clk); @(negedge clk);
        chk("R1 basic stub", 64'(stub_vec), 64'(b));
        chk("R5 trig", 64'(trig), 64'd1);
        apply(b, NCH'(1) << 13, '0, '0, 4'd2, 3'd0, "R1 outside window");
    endtask

    task automatic t_half();
        apply(NCH'(1) << 10, NCH'(1) << 12, '0, '0, 4'd1, 3'd0, "R2 half 1");
        apply(NCH'(1) << 10, NCH'(1) << 10, '0, '0, 4'd0, 3'd0, "R2 half 0 centre");
        apply(NCH'(1) << 10, NCH'(1) << 18, '0, '0, 4'd15, 3'd0, "R2 half 15 at 8");
        apply(NCH'(1) << 10, NCH'(1) << 19, '0, '0, 4'd15, 3'd0, "R2 half 15 at 9");
    endtask

    task automatic t_offset();
        apply(NCH'(1) << 10, NCH'(1) << 13, '0, '0, 4'd0, 3'd3, "R3 off +3");
        apply(NCH'(1) << 10, NCH'(1) << 7, '0, '0, 4'd0, 3'b101, "R3 off -3");
        apply(NCH'(1) << 10, NCH'(1) << 7, '0, '0, 4'd0, 3'b100, "R3 off -4 as -3");
        apply(NCH'(1) << 10, NCH'(1) << 6, '0, '0, 4'd0, 3'b100, "R3 off -4 not -4");
    endtask

    task automatic t_neighbour();
        apply(NCH'(1) << (NCH - 2), '0, '0, 11'(1) << 3, 4'd7, 3'd0, "R1 upper neighbour");
        apply(NCH'(1) << 1, '0, 11'(1) << 5, '0, 4'd7, 3'd0, "R1 lower neighbour");
        apply('0, NCH'(1) << 5, 11'h7FF, 11'h7FF, 4'd8, 3'd0, "R4 top only");
        apply(NCH'(1), '0, 11'h3FF, '0, 4'd8, 3'b100, "R4 beyond reach");
        apply(NCH'(1), '0, 11'h400, '0, 4'd8, 3'b101, "R4 reach edge");
    endtask

    task automatic t_edge_out();
        logic [NCH-1:0] t;
        t = 32'hC0A5_0F31;
        top_clu = t;
        #1;
        for (int k = 0; k < EDGE; k++) begin
            chk("R6 to_lo", 64'(top_to_lo[k]), 64'(t[k]));
            chk("R6 to_hi", 64'(top_to_hi[k]), 64'(t[NCH - 1 - k]));
        end
    endtask

    task automatic t_random();
        for (int n = 0; n < 24; n++)
            apply($urandom & $urandom, $urandom & $urandom, 11'($urandom), 11'($urandom),
                  4'($urandom), 3'($urandom), "R1 random");
    endtask

    task automatic t_shift();
        logic [NCH-1:0] b;
        logic [NCH-1:0] t;
        logic [NCH-1:0] e;
        logic [NCH-1:0] e2;
        b = 32'h8001_2481; t = 32'h4003_4902;
        e = model(b, t, '0, '0, 4'd1, 3'd0);
        bot_clu = b; top_clu = t; top_from_lo = '0; top_from_hi = '0;
        cfg_half = 4'd1; cfg_off = 3'd0; sr_load = 1'b1;
        @(posedge clk); @(negedge clk);
        sr_load = 1'b0;
        chk("R7 trig same edge as load", 64'(trig), 64'(|e));
        for (int k = 0; k < NCH; k++) begin
            chk("R7 valid", 64'(sr_valid), 64'd1);
            chk("R7 serial bit", 64'(sr_out), 64'(e[k]));
            @(posedge clk); @(negedge clk);
        end
        chk("R7 valid ends", 64'(sr_valid), 64'd0);
        chk("R10 idle out", 64'(sr_out), 64'd0);
        // reload during shifting
        sr_load = 1'b1;
        @(posedge clk); @(negedge clk);
        sr_load = 1'b0;
        for (int k = 0; k < 5; k++) begin
            chk("R8 first run bit", 64'(sr_out), 64'(e[k]));
            @(posedge clk); @(negedge clk);
        end
        b = 32'h0000_FFFF; t = 32'h0000_0F0F;
        e2 = model(b, t, '0, '0, 4'd1, 3'd0);
        bot_clu = b; top_clu = t; sr_load = 1'b1;
        @(posedge clk); @(negedge clk);
        sr_load = 1'b0;
        for (int k = 0; k < NCH; k++) begin
            chk("R8 reload valid", 64'(sr_valid), 64'd1);
            chk("R8 reload bit", 64'(sr_out), 64'(e2[k]));
            @(posedge clk); @(negedge clk);
        end
        chk("R8 reload ends", 64'(sr_valid), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; cfg_half = '0; cfg_off = '0; bot_clu = '0; top_clu = '0;
        top_from_lo = '0; top_from_hi = '0; sr_load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_half();
        t_offset();
        t_neighbour();
        t_edge_out();
        t_random();
        t_shift();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule